// File: doc/BRIEF.md
# Tagged Message Send/Receive Matcher

This block pairs outgoing message descriptors with posted receive requests for a message-passing node. A send descriptor carries the sending process, the process it is addressed to, a tag and a handle to the data. A receive request carries the process that owns it, the source it expects, the tag it expects and a handle to local storage. The source and the tag of a receive can each be replaced by a wildcard. Sends and receives that find no partner wait in two small age-ordered tables. When a compatible pair meets, the block issues one match event that carries both handles, so that a copy engine further on can move the data. The copy, protection and transport lie outside this block.

Either side may arrive first, and both can arrive in the same cycle. A send that meets a waiting receive produces an event on the send-side event port. A receive that meets a waiting send produces an event on the receive-side event port. Both ports can fire in the same cycle. Each table refuses new requests through its ready signal while it is full, and no request is ever dropped.

Top module: `msg_matcher`

## Requirements
- R1: During reset and afterwards, until traffic arrives, both tables are empty, both ready outputs are high and both event valids are low. While an event valid is low, every field of that event port reads zero. A reset discards all entries that are waiting.
- R2: A send accepted on the clock edge where snd_valid and snd_ready are both high is compared with the waiting receives. If one is compatible, ms_valid is high for the following cycle with the send's fields and the receive's handle, and that receive leaves the table. Otherwise the send is stored.
- R3: A receive accepted on the edge where rcv_valid and rcv_ready are both high is compared with the waiting sends. If one is compatible, mr_valid is high for the following cycle with the send's src, dst, tag and handle and with the receive's handle, and that send leaves the table. Otherwise the receive is stored.
- R4: A send and a receive are compatible only when snd_dst equals rcv_owner, when the sources are equal or rcv_src_any is 1, and when the tags are equal or rcv_tag_any is 1. The two wildcard bits act independently.
- R5: A send whose destination, source or tag does not fit any waiting receive produces no event and stays stored.
- R6: When several waiting entries are compatible, the one that was stored earliest is chosen.
- R7: snd_ready is low exactly while SEND_DEPTH sends are waiting, and rcv_ready is low exactly while RECV_DEPTH receives are waiting. A request that is offered while ready is low is not taken. Stored requests are never lost.
- R8: When a send and a receive are accepted on the same edge, the send is first compared with the receives that were already waiting. The new receive is then compared with the send table as updated by that step, which includes the new send if the new send found no partner.
- R9: Each stored entry takes part in at most one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| snd_valid | input | 1 | Send descriptor offered |
| snd_ready | output | 1 | Send table has room |
| snd_src | input | PID_W | Sending process |
| snd_dst | input | PID_W | Destination process |
| snd_tag | input | TAG_W | Message tag |
| snd_hdl | input | HDL_W | Handle of data to transmit |
| rcv_valid | input | 1 | Receive request offered |
| rcv_ready | output | 1 | Receive table has room |
| rcv_owner | input | PID_W | Process posting the receive |
| rcv_src | input | PID_W | Expected sending process |
| rcv_src_any | input | 1 | 1: accept any source |
| rcv_tag | input | TAG_W | Expected tag |
| rcv_tag_any | input | 1 | 1: accept any tag |
| rcv_hdl | input | HDL_W | Handle of local storage |
| ms_valid | output | 1 | Event caused by an arriving send |
| ms_src | output | PID_W | Source of the matched send |
| ms_dst | output | PID_W | Destination of the matched send |
| ms_tag | output | TAG_W | Tag of the matched send |
| ms_snd_hdl | output | HDL_W | Send data handle |
| ms_rcv_hdl | output | HDL_W | Receive buffer handle |
| mr_valid | output | 1 | Event caused by an arriving receive |
| mr_src | output | PID_W | Source of the matched send |
| mr_dst | output | PID_W | Destination of the matched send |
| mr_tag | output | TAG_W | Tag of the matched send |
| mr_snd_hdl | output | HDL_W | Send data handle |
| mr_rcv_hdl | output | HDL_W | Receive buffer handle |

## Verification
Every event is registered. An event is due exactly one cycle after the edge that accepts the request which causes it, and it is valid for that one cycle only. The ready outputs follow the table occupancy and change on that same accepting edge. The bench drives inputs just after a falling edge and lets one rising edge accept them. It samples both event ports and both ready outputs at the next falling edge, where the cycle-after result is settled. A later idle cycle confirms that the event has gone back to zero.

// File: rtl/msg_match_pkg.sv
package msg_match_pkg;

    localparam int PID_W = 4;
    localparam int TAG_W = 4;
    localparam int HDL_W = 8;

    typedef logic [PID_W-1:0] pid_t;
    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [HDL_W-1:0] hdl_t;

    typedef struct packed {
        pid_t src;
        pid_t dst;
        tag_t tag;
        hdl_t hdl;
    } snd_desc_t;

    typedef struct packed {
        pid_t owner;
        pid_t src;
        logic src_any;
        tag_t tag;
        logic tag_any;
        hdl_t hdl;
    } rcv_desc_t;

    typedef struct packed {
        pid_t src;
        pid_t dst;
        tag_t tag;
        hdl_t snd_hdl;
        hdl_t rcv_hdl;
    } match_evt_t;

    // Compatibility rule: owner must be the addressee, source and tag
    // must agree unless the receive waives them.
    function automatic logic pair_ok(input snd_desc_t s, input rcv_desc_t r);
        return (s.dst == r.owner) &&
               (r.src_any || (s.src == r.src)) &&
               (r.tag_any || (s.tag == r.tag));
    endfunction

    function automatic match_evt_t join_pair(input snd_desc_t s, input rcv_desc_t r);
        match_evt_t e;
        e.src     = s.src;
        e.dst     = s.dst;
        e.tag     = s.tag;
        e.snd_hdl = s.hdl;
        e.rcv_hdl = r.hdl;
        return e;
    endfunction

endpackage

// File: rtl/mm_first_hit.sv
module mm_first_hit #(
    parameter  int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    // Lowest index wins: index 0 holds the oldest entry.
    always_comb begin
        hit = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/mm_rcv_scan.sv
module mm_rcv_scan
    import msg_match_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  snd_desc_t               probe,
    input  rcv_desc_t [DEPTH-1:0]   tab,
    input  logic      [CW-1:0]      cnt,
    output logic                    hit,
    output logic      [IW-1:0]      idx
);

    logic [DEPTH-1:0] hv;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hv[g] = (CW'(g) < cnt) && pair_ok(probe, tab[g]);
    end

    mm_first_hit #(.N(DEPTH)) u_pick (
        .req (hv),
        .hit (hit),
        .idx (idx)
    );

endmodule

// File: rtl/mm_snd_scan.sv
module mm_snd_scan
    import msg_match_pkg::*;
#(
    parameter  int DEPTH = 4,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  rcv_desc_t               probe,
    input  snd_desc_t [DEPTH-1:0]   tab,
    input  logic      [CW-1:0]      cnt,
    output logic                    hit,
    output logic      [IW-1:0]      idx
);

    logic [DEPTH-1:0] hv;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign hv[g] = (CW'(g) < cnt) && pair_ok(tab[g], probe);
    end

    mm_first_hit #(.N(DEPTH)) u_pick (
        .req (hv),
        .hit (hit),
        .idx (idx)
    );

endmodule

// File: rtl/msg_matcher.sv
module msg_matcher
    import msg_match_pkg::*;
#(
    parameter int SEND_DEPTH = 4,
    parameter int RECV_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snd_valid,
    output logic             snd_ready,
    input  logic [PID_W-1:0] snd_src,
    input  logic [PID_W-1:0] snd_dst,
    input  logic [TAG_W-1:0] snd_tag,
    input  logic [HDL_W-1:0] snd_hdl,
    input  logic             rcv_valid,
    output logic             rcv_ready,
    input  logic [PID_W-1:0] rcv_owner,
    input  logic [PID_W-1:0] rcv_src,
    input  logic             rcv_src_any,
    input  logic [TAG_W-1:0] rcv_tag,
    input  logic             rcv_tag_any,
    input  logic [HDL_W-1:0] rcv_hdl,
    output logic             ms_valid,
    output logic [PID_W-1:0] ms_src,
    output logic [PID_W-1:0] ms_dst,
    output logic [TAG_W-1:0] ms_tag,
    output logic [HDL_W-1:0] ms_snd_hdl,
    output logic [HDL_W-1:0] ms_rcv_hdl,
    output logic             mr_valid,
    output logic [PID_W-1:0] mr_src,
    output logic [PID_W-1:0] mr_dst,
    output logic [TAG_W-1:0] mr_tag,
    output logic [HDL_W-1:0] mr_snd_hdl,
    output logic [HDL_W-1:0] mr_rcv_hdl
);

    localparam int SCW = $clog2(SEND_DEPTH + 1);
    localparam int SIW = (SEND_DEPTH > 1) ? $clog2(SEND_DEPTH) : 1;
    localparam int RCW = $clog2(RECV_DEPTH + 1);
    localparam int RIW = (RECV_DEPTH > 1) ? $clog2(RECV_DEPTH) : 1;

    typedef snd_desc_t [SEND_DEPTH-1:0] snd_tab_t;
    typedef rcv_desc_t [RECV_DEPTH-1:0] rcv_tab_t;

    // Age-ordered tables: entry 0 is the oldest, entries at or above
    // the count are empty.
    snd_tab_t         s_tab_q;
    rcv_tab_t         r_tab_q;
    logic [SCW-1:0]   s_cnt_q;
    logic [RCW-1:0]   r_cnt_q;

    match_evt_t       ms_evt_q, mr_evt_q;
    logic             ms_v_q, mr_v_q;

    // ---------------- table edit helpers ----------------
    function automatic snd_tab_t snd_drop(input snd_tab_t t, input logic [SIW-1:0] k);
        for (int i = 0; i < SEND_DEPTH - 1; i++) begin
            if (i >= int'(k)) t[i] = t[i+1];
        end
        t[SEND_DEPTH-1] = '0;
        return t;
    endfunction

    function automatic snd_tab_t snd_put(input snd_tab_t t, input logic [SCW-1:0] c,
                                         input snd_desc_t d);
        for (int i = 0; i < SEND_DEPTH; i++) begin
            if (SCW'(i) == c) t[i] = d;
        end
        return t;
    endfunction

    function automatic rcv_tab_t rcv_drop(input rcv_tab_t t, input logic [RIW-1:0] k);
        for (int i = 0; i < RECV_DEPTH - 1; i++) begin
            if (i >= int'(k)) t[i] = t[i+1];
        end
        t[RECV_DEPTH-1] = '0;
        return t;
    endfunction

    function automatic rcv_tab_t rcv_put(input rcv_tab_t t, input logic [RCW-1:0] c,
                                         input rcv_desc_t d);
        for (int i = 0; i < RECV_DEPTH; i++) begin
            if (RCW'(i) == c) t[i] = d;
        end
        return t;
    endfunction

    // ---------------- request capture ----------------
    snd_desc_t snd_in;
    rcv_desc_t rcv_in;
    logic      snd_fire, rcv_fire;

    always_comb begin
        snd_in.src     = snd_src;
        snd_in.dst     = snd_dst;
        snd_in.tag     = snd_tag;
        snd_in.hdl     = snd_hdl;
        rcv_in.owner   = rcv_owner;
        rcv_in.src     = rcv_src;
        rcv_in.src_any = rcv_src_any;
        rcv_in.tag     = rcv_tag;
        rcv_in.tag_any = rcv_tag_any;
        rcv_in.hdl     = rcv_hdl;
    end

    assign snd_ready = (s_cnt_q != SCW'(SEND_DEPTH));
    assign rcv_ready = (r_cnt_q != RCW'(RECV_DEPTH));
    assign snd_fire  = snd_valid && snd_ready;
    assign rcv_fire  = rcv_valid && rcv_ready;

    // ---------------- stage A: new send against waiting receives ----------------
    logic             a_hit;
    logic [RIW-1:0]   a_idx;
    snd_tab_t         s_tab_a;
    rcv_tab_t         r_tab_a;
    logic [SCW-1:0]   s_cnt_a;
    logic [RCW-1:0]   r_cnt_a;
    match_evt_t       ev_s;
    logic             ev_s_v;

    mm_rcv_scan #(.DEPTH(RECV_DEPTH)) u_scan_a (
        .probe (snd_in),
        .tab   (r_tab_q),
        .cnt   (r_cnt_q),
        .hit   (a_hit),
        .idx   (a_idx)
    );

    always_comb begin
        s_tab_a = s_tab_q;
        s_cnt_a = s_cnt_q;
        r_tab_a = r_tab_q;
        r_cnt_a = r_cnt_q;
        ev_s    = '0;
        ev_s_v  = 1'b0;
        if (snd_fire) begin
            if (a_hit) begin
                ev_s_v  = 1'b1;
                ev_s    = join_pair(snd_in, r_tab_q[a_idx]);
                r_tab_a = rcv_drop(r_tab_q, a_idx);
                r_cnt_a = r_cnt_q - RCW'(1);
            end else begin
                s_tab_a = snd_put(s_tab_q, s_cnt_q, snd_in);
                s_cnt_a = s_cnt_q + SCW'(1);
            end
        end
    end

    // ---------------- stage B: new receive against updated send table ----------------
    logic             b_hit;
    logic [SIW-1:0]   b_idx;
    snd_tab_t         s_tab_n;
    rcv_tab_t         r_tab_n;
    logic [SCW-1:0]   s_cnt_n;
    logic [RCW-1:0]   r_cnt_n;
    match_evt_t       ev_r;
    logic             ev_r_v;

    mm_snd_scan #(.DEPTH(SEND_DEPTH)) u_scan_b (
        .probe (rcv_in),
        .tab   (s_tab_a),
        .cnt   (s_cnt_a),
        .hit   (b_hit),
        .idx   (b_idx)
    );

    always_comb begin
        s_tab_n = s_tab_a;
        s_cnt_n = s_cnt_a;
        r_tab_n = r_tab_a;
        r_cnt_n = r_cnt_a;
        ev_r    = '0;
        ev_r_v  = 1'b0;
        if (rcv_fire) begin
            if (b_hit) begin
                ev_r_v  = 1'b1;
                ev_r    = join_pair(s_tab_a[b_idx], rcv_in);
                s_tab_n = snd_drop(s_tab_a, b_idx);
                s_cnt_n = s_cnt_a - SCW'(1);
            end else begin
                r_tab_n = rcv_put(r_tab_a, r_cnt_a, rcv_in);
                r_cnt_n = r_cnt_a + RCW'(1);
            end
        end
    end

    // ---------------- state ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            s_tab_q  <= '0;
            r_tab_q  <= '0;
            s_cnt_q  <= '0;
            r_cnt_q  <= '0;
            ms_evt_q <= '0;
            mr_evt_q <= '0;
            ms_v_q   <= 1'b0;
            mr_v_q   <= 1'b0;
        end else begin
            s_tab_q  <= s_tab_n;
            r_tab_q  <= r_tab_n;
            s_cnt_q  <= s_cnt_n;
            r_cnt_q  <= r_cnt_n;
            ms_evt_q <= ev_s;
            mr_evt_q <= ev_r;
            ms_v_q   <= ev_s_v;
            mr_v_q   <= ev_r_v;
        end
    end

    assign ms_valid   = ms_v_q;
    assign ms_src     = ms_evt_q.src;
    assign ms_dst     = ms_evt_q.dst;
    assign ms_tag     = ms_evt_q.tag;
    assign ms_snd_hdl = ms_evt_q.snd_hdl;
    assign ms_rcv_hdl = ms_evt_q.rcv_hdl;
    assign mr_valid   = mr_v_q;
    assign mr_src     = mr_evt_q.src;
    assign mr_dst     = mr_evt_q.dst;
    assign mr_tag     = mr_evt_q.tag;
    assign mr_snd_hdl = mr_evt_q.snd_hdl;
    assign mr_rcv_hdl = mr_evt_q.rcv_hdl;

endmodule

// File: rtl/msg_matcher_chk.sv
module msg_matcher_chk
    import msg_match_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             snd_valid,
    input logic             snd_ready,
    input logic [PID_W-1:0] snd_src,
    input logic [PID_W-1:0] snd_dst,
    input logic [TAG_W-1:0] snd_tag,
    input logic [HDL_W-1:0] snd_hdl,
    input logic             rcv_valid,
    input logic             rcv_ready,
    input logic [PID_W-1:0] rcv_owner,
    input logic [PID_W-1:0] rcv_src,
    input logic             rcv_src_any,
    input logic [TAG_W-1:0] rcv_tag,
    input logic             rcv_tag_any,
    input logic [HDL_W-1:0] rcv_hdl,
    input logic             ms_valid,
    input logic [PID_W-1:0] ms_src,
    input logic [PID_W-1:0] ms_dst,
    input logic [TAG_W-1:0] ms_tag,
    input logic [HDL_W-1:0] ms_snd_hdl,
    input logic [HDL_W-1:0] ms_rcv_hdl,
    input logic             mr_valid,
    input logic [PID_W-1:0] mr_src,
    input logic [PID_W-1:0] mr_dst,
    input logic [TAG_W-1:0] mr_tag,
    input logic [HDL_W-1:0] mr_snd_hdl,
    input logic [HDL_W-1:0] mr_rcv_hdl
);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (snd_ready && rcv_ready && !ms_valid && !mr_valid)); // R1

    AST_MS_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !ms_valid |-> (ms_src == '0 && ms_dst == '0 && ms_tag == '0 &&
                       ms_snd_hdl == '0 && ms_rcv_hdl == '0)); // R1

    AST_MR_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !mr_valid |-> (mr_src == '0 && mr_dst == '0 && mr_tag == '0 &&
                       mr_snd_hdl == '0 && mr_rcv_hdl == '0)); // R1

    AST_MS_NEEDS_SEND: assert property (@(posedge clk) disable iff (rst)
        !(snd_valid && snd_ready) |=> !ms_valid); // R2

    AST_MS_CARRIES_SEND: assert property (@(posedge clk) disable iff (rst)
        (snd_valid && snd_ready) |=>
            (!ms_valid || (ms_src == $past(snd_src) && ms_dst == $past(snd_dst) &&
                           ms_tag == $past(snd_tag) && ms_snd_hdl == $past(snd_hdl)))); // R2

    AST_MR_NEEDS_RECV: assert property (@(posedge clk) disable iff (rst)
        !(rcv_valid && rcv_ready) |=> !mr_valid); // R3

    AST_MR_CARRIES_RECV: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && rcv_ready) |=>
            (!mr_valid || (mr_dst == $past(rcv_owner) && mr_rcv_hdl == $past(rcv_hdl)))); // R3

    AST_SRC_RULE: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && rcv_ready && !rcv_src_any) |=>
            (!mr_valid || mr_src == $past(rcv_src))); // R4

    AST_TAG_RULE: assert property (@(posedge clk) disable iff (rst)
        (rcv_valid && rcv_ready && !rcv_tag_any) |=>
            (!mr_valid || mr_tag == $past(rcv_tag))); // R4

endmodule

bind msg_matcher msg_matcher_chk u_chk (.*);

// File: tb/msg_matcher_test.sv
module msg_matcher_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       snd_valid = 1'b0;
    logic       snd_ready;
    logic [3:0] snd_src = '0, snd_dst = '0, snd_tag = '0;
    logic [7:0] snd_hdl = '0;
    logic       rcv_valid = 1'b0;
    logic       rcv_ready;
    logic [3:0] rcv_owner = '0, rcv_src = '0, rcv_tag = '0;
    logic       rcv_src_any = 1'b0, rcv_tag_any = 1'b0;
    logic [7:0] rcv_hdl = '0;
    logic       ms_valid, mr_valid;
    logic [3:0] ms_src, ms_dst, ms_tag, mr_src, mr_dst, mr_tag;
    logic [7:0] ms_snd_hdl, ms_rcv_hdl, mr_snd_hdl, mr_rcv_hdl;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    msg_matcher uut (
        .clk, .rst,
        .snd_valid, .snd_ready, .snd_src, .snd_dst, .snd_tag, .snd_hdl,
        .rcv_valid, .rcv_ready, .rcv_owner, .rcv_src, .rcv_src_any,
        .rcv_tag, .rcv_tag_any, .rcv_hdl,
        .ms_valid, .ms_src, .ms_dst, .ms_tag, .ms_snd_hdl, .ms_rcv_hdl,
        .mr_valid, .mr_src, .mr_dst, .mr_tag, .mr_snd_hdl, .mr_rcv_hdl
    );

    typedef struct packed {
        logic       do_s;
        logic [3:0] s_src, s_dst, s_tag;
        logic [7:0] s_hdl;
        logic       do_r;
        logic [3:0] r_own, r_src;
        logic       r_sany;
        logic [3:0] r_tag;
        logic       r_tany;
        logic [7:0] r_hdl;
        logic       x_ms;
        logic [7:0] x_ms_rh;
        logic       x_mr;
        logic [7:0] x_mr_sh;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        // 0: send waits
        '{1'b1,4'h1,4'h2,4'h3,8'h10, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        // 1: receive meets it (R3)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h2,4'h1,1'b0,4'h3,1'b0,8'h20, 1'b0,8'h00, 1'b1,8'h10},
        // 2: receive waits
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h2,4'h5,1'b0,4'h1,1'b0,8'h21, 1'b0,8'h00, 1'b0,8'h00},
        // 3-5: destination, tag, source mismatches held (R5)
        '{1'b1,4'h5,4'h3,4'h1,8'h11, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'h5,4'h2,4'h2,8'h12, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'h6,4'h2,4'h1,8'h13, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        // 6: send meets waiting receive (R2)
        '{1'b1,4'h5,4'h2,4'h1,8'h14, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b1,8'h21, 1'b0,8'h00},
        // 7: source wildcard (R4)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h2,4'h0,1'b1,4'h1,1'b0,8'h22, 1'b0,8'h00, 1'b1,8'h13},
        // 8: tag wildcard (R4)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h2,4'h5,1'b0,4'h0,1'b1,8'h23, 1'b0,8'h00, 1'b1,8'h12},
        // 9: both wildcards (R4)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h3,4'h0,1'b1,4'h0,1'b1,8'h24, 1'b0,8'h00, 1'b1,8'h11},
        // 10-13: arrival order kept, each send used once (R6, R9)
        '{1'b1,4'h7,4'h1,4'h4,8'h15, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'h7,4'h1,4'h4,8'h16, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h1,4'h7,1'b0,4'h4,1'b0,8'h25, 1'b0,8'h00, 1'b1,8'h15},
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h1,4'h7,1'b0,4'h4,1'b0,8'h26, 1'b0,8'h00, 1'b1,8'h16},
        // 14: same edge, empty tables: new receive finds the new send (R8)
        '{1'b1,4'h8,4'h1,4'h5,8'h17, 1'b1,4'h1,4'h8,1'b0,4'h5,1'b0,8'h27, 1'b0,8'h00, 1'b1,8'h17},
        // 15-17: send takes old receive first, new receive waits (R8)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h1,4'h9,1'b0,4'h6,1'b0,8'h28, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'h9,4'h1,4'h6,8'h18, 1'b1,4'h1,4'h9,1'b0,4'h6,1'b0,8'h29, 1'b1,8'h28, 1'b0,8'h00},
        '{1'b1,4'h9,4'h1,4'h6,8'h19, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b1,8'h29, 1'b0,8'h00},
        // 18-20: both ports fire on one edge (R8)
        '{1'b0,4'h0,4'h0,4'h0,8'h00, 1'b1,4'h1,4'hA,1'b0,4'h7,1'b0,8'h2A, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'hB,4'h1,4'h8,8'h1A, 1'b0,4'h0,4'h0,1'b0,4'h0,1'b0,8'h00, 1'b0,8'h00, 1'b0,8'h00},
        '{1'b1,4'hA,4'h1,4'h7,8'h1B, 1'b1,4'h1,4'hB,1'b0,4'h8,1'b0,8'h2B, 1'b1,8'h2A, 1'b1,8'h1A}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    // Drive after a falling edge, let one rising edge accept, return at the
    // next falling edge with the valids dropped.
    task automatic issue(input vec_t v);
        @(negedge clk);
        snd_valid = v.do_s; snd_src = v.s_src; snd_dst = v.s_dst;
        snd_tag = v.s_tag; snd_hdl = v.s_hdl;
        rcv_valid = v.do_r; rcv_owner = v.r_own; rcv_src = v.r_src;
        rcv_src_any = v.r_sany; rcv_tag = v.r_tag; rcv_tag_any = v.r_tany;
        rcv_hdl = v.r_hdl;
        @(posedge clk);
        @(negedge clk);
        snd_valid = 1'b0;
        rcv_valid = 1'b0;
    endtask

    function automatic vec_t mk_s(input logic [3:0] s, d, t, input logic [7:0] h);
        vec_t v = '0;
        v.do_s = 1'b1; v.s_src = s; v.s_dst = d; v.s_tag = t; v.s_hdl = h;
        return v;
    endfunction

    function automatic vec_t mk_r(input logic [3:0] o, s, input logic sa,
                                  input logic [3:0] t, input logic ta, input logic [7:0] h);
        vec_t v = '0;
        v.do_r = 1'b1; v.r_own = o; v.r_src = s; v.r_sany = sa;
        v.r_tag = t; v.r_tany = ta; v.r_hdl = h;
        return v;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        chk("R1 snd_ready after reset", snd_ready, 1);
        chk("R1 rcv_ready after reset", rcv_ready, 1);
        chk("R1 ms_valid after reset", ms_valid, 0);
        chk("R1 mr_valid after reset", mr_valid, 0);

        for (int k = 0; k < NV; k++) begin
            issue(VEC[k]);
            chk($sformatf("R2 vec%0d ms_valid", k), ms_valid, VEC[k].x_ms);
            if (VEC[k].x_ms)
                chk($sformatf("R2 vec%0d ms_rcv_hdl", k), ms_rcv_hdl, VEC[k].x_ms_rh);
            chk($sformatf("R3 vec%0d mr_valid", k), mr_valid, VEC[k].x_mr);
            if (VEC[k].x_mr)
                chk($sformatf("R3 vec%0d mr_snd_hdl", k), mr_snd_hdl, VEC[k].x_mr_sh);
        end

        // R1: one idle cycle later the event port reads zero again
        @(negedge clk);
        chk("R1 idle ms_valid", ms_valid, 0);
        chk("R1 idle ms_rcv_hdl", ms_rcv_hdl, 0);
        chk("R1 idle mr_snd_hdl", mr_snd_hdl, 0);

        // R7: fill the send table
        for (int i = 0; i < 4; i++) begin
            issue(mk_s(4'h1, 4'h9, 4'(i + 1), 8'(8'h31 + i)));
            chk("R5 unmatched send no event", ms_valid, 0);
        end
        chk("R7 snd_ready low when full", snd_ready, 0);
        chk("R7 rcv_ready still high", rcv_ready, 1);
        issue(mk_s(4'h1, 4'h9, 4'h5, 8'h35));   // offered while not ready
        chk("R7 refused send no event", ms_valid, 0);
        chk("R7 snd_ready stays low", snd_ready, 0);
        issue(mk_r(4'h9, 4'h1, 1'b0, 4'h1, 1'b0, 8'h41));
        chk("R7 stored send survives", mr_valid, 1);
        chk("R7 stored send handle", mr_snd_hdl, 8'h31);
        chk("R7 snd_ready back high", snd_ready, 1);
        issue(mk_r(4'h9, 4'h1, 1'b0, 4'h5, 1'b0, 8'h42));
        chk("R7 refused send was not taken", mr_valid, 0);
        issue(mk_r(4'h9, 4'h1, 1'b0, 4'h0, 1'b1, 8'h43));
        chk("R6 tag wildcard picks oldest", mr_snd_hdl, 8'h32);
        issue(mk_r(4'h9, 4'h0, 1'b1, 4'h4, 1'b0, 8'h44));
        chk("R4 source wildcard exact tag", mr_snd_hdl, 8'h34);
        issue(mk_r(4'h9, 4'h1, 1'b0, 4'h3, 1'b0, 8'h45));
        chk("R9 remaining send", mr_snd_hdl, 8'h33);

        // R7: fill the receive table (0x42 already waits)
        for (int i = 0; i < 3; i++) begin
            issue(mk_r(4'hC, 4'h0, 1'b0, 4'h0, 1'b0, 8'(8'h46 + i)));
            chk("R3 unmatched receive no event", mr_valid, 0);
        end
        chk("R7 rcv_ready low when full", rcv_ready, 0);
        issue(mk_s(4'h0, 4'hC, 4'h0, 8'h37));
        chk("R6 oldest receive chosen", ms_rcv_hdl, 8'h46);
        chk("R7 rcv_ready back high", rcv_ready, 1);

        // R1: reset discards waiting entries (0x42 would otherwise match)
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 snd_ready after mid reset", snd_ready, 1);
        chk("R1 rcv_ready after mid reset", rcv_ready, 1);
        issue(mk_r(4'h9, 4'h1, 1'b0, 4'h5, 1'b0, 8'h49));
        chk("R1 receive after reset waits", mr_valid, 0);
        issue(mk_s(4'h1, 4'h9, 4'h5, 8'h38));
        chk("R1 cleared entry gone", ms_rcv_hdl, 8'h49);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule